// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM whose data transfers follow their commands at a fixed distance. The address and control lines are captured on one rising clock edge. The matching data phase, whether a read or a write, falls two clocks later. Reads and writes share that same distance, so a controller can issue a new command on every clock and mix directions freely without idle cycles on the data bus.

A small burst engine is built in. A load command starts a four-word sequence at the supplied address. Each following advance command steps to the next word in the same direction, in either linear or interleaved order. A clock-enable input freezes the whole block. Three chip selects gate new loads, and an asynchronous output enable can silence the data outputs at any moment. The bidirectional data bus is split into an input, an output and a drive-enable, ready for a pad ring.

Top module: `zt_sram`

## Requirements
- R1: A selected load with `rd_wr`=1 sampled at edge k puts the addressed word on `dq_out` after edge k+2, with `dq_oe` high from then until edge k+3 whenever `oe_n` is low.
- R2: A write command sampled at edge k takes its data from `dq_in` at edge k+3. Lane b (bits 9b+8 down to 9b) is stored only if `byte_wen_n[b]` was low at edge k. Lanes that are not enabled keep their old contents.
- R3: Commands may be issued on consecutive clocks with any mix of directions. A read issued one clock after a write to the same address returns the newly written lanes merged with the old ones.
- R4: While `clk_en_n` is high at an edge, every input is ignored. `dq_out` and the pipeline state hold, and no memory word changes.
- R5: The device is selected only when `sel0_n`=0, `sel1_n`=0 and `sel2`=1. A load (`adv_ld`=0) sampled while not selected starts no operation. Commands already in the pipe still complete.
- R6: `dq_oe` is low during the data phase of a write, and low two cycles after a deselected load.
- R7: `oe_n` high forces `dq_oe` low at once, without waiting for a clock edge.
- R8: With `adv_ld`=1 after a selected load, each command moves to the next burst word in the load's direction. The two low address bits step from the base b as (b+n) mod 4 when `burst_lin`=1, and as b XOR n when `burst_lin`=0, for step n=1,2,3, and wrap after that.
- R9: An advance after a deselected load is a no-operation and never drives the bus.
- R10: While `rst` is high, and in the cycle after it falls, `dq_oe` is low and the pipeline holds no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high suspends the block |
| sel0_n | input | 1 | Chip select, active low |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| rd_wr | input | 1 | 1 = read, 0 = write, sampled on loads |
| adv_ld | input | 1 | 0 = load new address, 1 = advance burst |
| burst_lin | input | 1 | 1 = linear burst order, 0 = interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| byte_wen_n | input | NB | Per-lane write enables, active low |
| addr | input | AW | Word address |
| dq_in | input | NB*BW | Write data bus |
| dq_out | output | NB*BW | Read data bus |
| dq_oe | output | 1 | Read data drive enable |

## Verification
Each command sampled at edge k has results due at fixed points. Read data and `dq_oe` come after edge k+2. Write data is taken at edge k+3 and becomes visible through later reads. A stalled edge shifts both of these by one. The bench keeps a reference model that advances one stage per enabled edge. It applies stimulus at the falling edge and compares the outputs half a cycle after each rising edge, so every expected value is read in exactly the cycle the pipe delivers it. The bound properties count the same distances from the ports, and each one requires the intervening edges to be enabled.

// File: rtl/zt_sram_pkg.sv
`timescale 1ns/1ps
package zt_sram_pkg;
  localparam int BURST_LEN = 4;
  localparam int BL_W = $clog2(BURST_LEN);

  typedef enum logic {ORDER_XOR = 1'b0, ORDER_LIN = 1'b1} burst_order_e;

  // low address bits of burst word 'step' from base 'base'
  function automatic logic [BL_W-1:0] burst_lsb(input logic [BL_W-1:0] base,
                                                input logic [BL_W-1:0] step,
                                                input burst_order_e ord);
    return (ord == ORDER_LIN) ? base + step : base ^ step;
  endfunction
endpackage

// File: rtl/zt_front.sv
`timescale 1ns/1ps
module zt_front
  import zt_sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          adv,
  input  logic          sel,
  input  logic          rd,
  input  logic          lin,
  input  logic [AW-1:0] addr,
  input  logic [NB-1:0] bw,
  output logic          a_vld,
  output logic          a_wr,
  output logic [AW-1:0] a_addr,
  output logic [NB-1:0] a_bw
);
  logic            bst_act, bst_wr;
  logic [AW-1:0]   bst_base;
  logic [BL_W-1:0] bst_cnt, nxt_cnt;
  logic            iss_v, iss_wr;
  logic [AW-1:0]   iss_addr;
  burst_order_e    ord;

  assign ord = lin ? ORDER_LIN : ORDER_XOR;

  always_comb begin
    nxt_cnt = bst_cnt + 1'b1;
    if (!adv) begin
      iss_v    = sel;
      iss_wr   = !rd;
      iss_addr = addr;
    end else begin
      iss_v    = bst_act;
      iss_wr   = bst_wr;
      iss_addr = {bst_base[AW-1:BL_W], burst_lsb(bst_base[BL_W-1:0], nxt_cnt, ord)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bst_act  <= 1'b0;
      bst_wr   <= 1'b0;
      bst_base <= '0;
      bst_cnt  <= '0;
      a_vld    <= 1'b0;
      a_wr     <= 1'b0;
      a_addr   <= '0;
      a_bw     <= '0;
    end else if (run) begin
      if (!adv) begin
        bst_act <= sel;
        if (sel) begin
          bst_wr   <= !rd;
          bst_base <= addr;
          bst_cnt  <= '0;
        end
      end else if (bst_act) begin
        bst_cnt <= nxt_cnt;
      end
      a_vld  <= iss_v;
      a_wr   <= iss_wr;
      a_addr <= iss_addr;
      a_bw   <= bw;
    end
  end
endmodule

// File: rtl/zt_pipe.sv
`timescale 1ns/1ps
module zt_pipe #(
  parameter int W     = 14,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] din,
  output logic [W-1:0] tap_first,
  output logic [W-1:0] tap_last
);
  logic [DEPTH-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else if (run) begin
      st[0] <= din;
      for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
    end
  end

  assign tap_first = st[0];
  assign tap_last  = st[DEPTH-1];
endmodule

// File: rtl/zt_array.sv
`timescale 1ns/1ps
module zt_array #(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [NB-1:0]    wr_bw,
  input  logic [NB*BW-1:0] wr_data,
  output logic [NB*BW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic same;
  assign same = wr_en && (wr_addr == rd_addr);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BW-1:0] mem [DEPTH];
    logic [BW-1:0] q;

    always_ff @(posedge clk) begin
      if (run && wr_en && wr_bw[b]) mem[wr_addr] <= wr_data[b*BW +: BW];
    end

    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (run && rd_en)
        q <= (same && wr_bw[b]) ? wr_data[b*BW +: BW] : mem[rd_addr];
    end

    assign rd_data[b*BW +: BW] = q;
  end
endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram #(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en_n,
  input  logic             sel0_n,
  input  logic             sel1_n,
  input  logic             sel2,
  input  logic             rd_wr,
  input  logic             adv_ld,
  input  logic             burst_lin,
  input  logic             oe_n,
  input  logic [NB-1:0]    byte_wen_n,
  input  logic [AW-1:0]    addr,
  input  logic [NB*BW-1:0] dq_in,
  output logic [NB*BW-1:0] dq_out,
  output logic             dq_oe
);
  localparam int SW = 2 + AW + NB;

  logic          run, sel;
  logic          a_vld, a_wr;
  logic [AW-1:0] a_addr;
  logic [NB-1:0] a_bw;
  logic [SW-1:0] b_st, c_st;
  logic          b_vld, b_wr, c_vld, c_wr;
  logic [AW-1:0] b_addr, c_addr;
  logic [NB-1:0] b_bw, c_bw;

  assign run = !clk_en_n;
  assign sel = !sel0_n && !sel1_n && sel2;

  zt_front #(.AW(AW), .NB(NB)) u_front (
    .clk(clk), .rst(rst), .run(run), .adv(adv_ld), .sel(sel), .rd(rd_wr),
    .lin(burst_lin), .addr(addr), .bw(~byte_wen_n),
    .a_vld(a_vld), .a_wr(a_wr), .a_addr(a_addr), .a_bw(a_bw)
  );

  zt_pipe #(.W(SW), .DEPTH(2)) u_pipe (
    .clk(clk), .rst(rst), .run(run), .din({a_vld, a_wr, a_addr, a_bw}),
    .tap_first(b_st), .tap_last(c_st)
  );

  assign {b_vld, b_wr, b_addr, b_bw} = b_st;
  assign {c_vld, c_wr, c_addr, c_bw} = c_st;

  zt_array #(.AW(AW), .NB(NB), .BW(BW)) u_array (
    .clk(clk), .rst(rst), .run(run),
    .rd_en(b_vld && !b_wr), .rd_addr(b_addr),
    .wr_en(c_vld && c_wr), .wr_addr(c_addr), .wr_bw(c_bw), .wr_data(dq_in),
    .rd_data(dq_out)
  );

  assign dq_oe = c_vld && !c_wr && !oe_n;

  logic unused_b;
  assign unused_b = ^b_bw;
endmodule

// File: rtl/zt_sram_chk.sv
`timescale 1ns/1ps
module zt_sram_chk #(
  parameter int NB = 4,
  parameter int BW = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             clk_en_n,
  input logic             sel0_n,
  input logic             sel1_n,
  input logic             sel2,
  input logic             rd_wr,
  input logic             adv_ld,
  input logic             oe_n,
  input logic [NB*BW-1:0] dq_out,
  input logic             dq_oe
);
  logic sel_w;
  assign sel_w = !sel0_n && !sel1_n && sel2;

  // R1
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !adv_ld && sel_w && rd_wr) ##1 !clk_en_n ##1 !clk_en_n |=> (oe_n || dq_oe));

  // R6
  wr_phase_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !adv_ld && sel_w && !rd_wr) ##1 !clk_en_n ##1 !clk_en_n |=> !dq_oe);

  // R5
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !adv_ld && !sel_w) ##1 !clk_en_n ##1 !clk_en_n |=> !dq_oe);

  // R9
  noop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !adv_ld && !sel_w) ##1 (!clk_en_n && adv_ld) ##1 !clk_en_n ##1 !clk_en_n |=> !dq_oe);

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> $stable(dq_out));

  // R10
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !dq_oe);

  // R7
  always_comb begin
    if (rst === 1'b0 && oe_n === 1'b1) begin
      oe_async_chk: assert (dq_oe !== 1'b1);
    end
  end
endmodule

bind zt_sram zt_sram_chk #(.NB(NB), .BW(BW)) u_chk (.*);

// File: tb/tb_zt_sram.sv
`timescale 1ns/1ps
module tb_zt_sram;
  localparam int AW = 8, NB = 4, BW = 9, DW = NB * BW, DEPTH = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  logic clk_en_n = 1'b0, sel0_n = 1'b1, sel1_n = 1'b1, sel2 = 1'b0;
  logic rd_wr = 1'b1, adv_ld = 1'b0, burst_lin = 1'b1, oe_n = 1'b0;
  logic [NB-1:0] byte_wen_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  zt_sram #(.AW(AW), .NB(NB), .BW(BW)) dut (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .sel0_n(sel0_n), .sel1_n(sel1_n),
    .sel2(sel2), .rd_wr(rd_wr), .adv_ld(adv_ld), .burst_lin(burst_lin), .oe_n(oe_n),
    .byte_wen_n(byte_wen_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // reference model
  logic [DW-1:0] m_mem [DEPTH];
  bit m_act, m_bwr;
  bit [AW-1:0] m_base;
  bit [1:0] m_cnt;
  bit a_v, a_w, b_v, b_w, c_v, c_w;
  bit [AW-1:0] a_a, b_a, c_a;
  bit [NB-1:0] a_m, b_m, c_m;
  string a_tg = "R10", b_tg = "R10", c_tg = "R10";
  logic [DW-1:0] exp_q = '0;

  function automatic bit [AW-1:0] bst_addr(bit [AW-1:0] base, bit [1:0] n, bit lin);
    bit [1:0] lo;
    lo = lin ? base[1:0] + n : base[1:0] ^ n;
    return {base[AW-1:2], lo};
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, bit [NB-1:0] m);
    logic [DW-1:0] r;
    r = old;
    for (int b = 0; b < NB; b++) if (m[b]) r[b*BW +: BW] = nw[b*BW +: BW];
    return r;
  endfunction

  task automatic chk(bit ok, string r, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic model_edge(string itag);
    bit s;
    if (rst) begin
      a_v = 0; b_v = 0; c_v = 0; m_act = 0;
      a_tg = "R10"; b_tg = "R10"; c_tg = "R10";
      return;
    end
    if (clk_en_n) return;
    if (b_v && !b_w) begin
      exp_q = m_mem[b_a];
      if (c_v && c_w && c_a == b_a) begin
        exp_q = merge(exp_q, dq_in, c_m);
        b_tg = "R3";
      end
    end
    if (c_v && c_w) m_mem[c_a] = merge(m_mem[c_a], dq_in, c_m);
    c_v = b_v; c_w = b_w; c_a = b_a; c_m = b_m; c_tg = b_tg;
    b_v = a_v; b_w = a_w; b_a = a_a; b_m = a_m; b_tg = a_tg;
    s = !sel0_n && !sel1_n && sel2;
    a_m = ~byte_wen_n;
    if (!adv_ld) begin
      a_v = s; a_w = !rd_wr; a_a = addr;
      a_tg = s ? (rd_wr ? "R1" : "R6") : "R5";
      m_act = s;
      if (s) begin m_bwr = !rd_wr; m_base = addr; m_cnt = 0; end
    end else if (m_act) begin
      m_cnt++;
      a_v = 1; a_w = m_bwr; a_a = bst_addr(m_base, m_cnt, burst_lin);
      a_tg = m_bwr ? "R6" : "R8";
    end else begin
      a_v = 0; a_tg = "R9";
    end
    if (itag != "") a_tg = itag;
  endtask

  // one clock: drive at falling edge, check, then model the rising edge
  task automatic cyc(bit en_n, bit s0, bit s1, bit s2, bit rw, bit adv, bit lin,
                     bit [NB-1:0] bwn, bit [AW-1:0] ad, bit oe, string ctag, string itag);
    bit exp_oe;
    clk_en_n = en_n; sel0_n = s0; sel1_n = s1; sel2 = s2; rd_wr = rw; adv_ld = adv;
    burst_lin = lin; byte_wen_n = bwn; addr = ad; oe_n = oe;
    dq_in = {$urandom, $urandom};
    #1;
    exp_oe = c_v && !c_w && !oe;
    chk(dq_oe === exp_oe, (ctag != "") ? ctag : c_tg, DW'(dq_oe), DW'(exp_oe));
    if (exp_oe) chk(dq_out === exp_q, (ctag != "") ? ctag : c_tg, dq_out, exp_q);
    @(posedge clk);
    model_edge(itag);
    @(negedge clk);
  endtask

  task automatic ld(bit rw, bit [AW-1:0] ad, bit [NB-1:0] bwn, string itag);
    cyc(0, 0, 0, 1, rw, 0, 1, bwn, ad, 0, "", itag);
  endtask
  task automatic adv(bit lin, string itag);
    cyc(0, 0, 0, 1, 1, 1, lin, '0, '0, 0, "", itag);
  endtask
  task automatic desel();
    cyc(0, 1, 0, 1, 1, 0, 1, '1, '0, 0, "", "R5");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R10: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    // R10: reset keeps the bus quiet
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 1, 0, 1, '1, 8'(i), 0, "R10", "");
    rst = 1'b0;
    cyc(0, 1, 1, 0, 1, 1, 1, '1, '0, 0, "R10", "");
    // R3: preload with back-to-back writes, full lanes
    for (int i = 0; i < DEPTH; i++) ld(0, 8'(i), '0, "");
    for (int i = 0; i < 3; i++) desel();
    // R2: partial lane write (lanes 0 and 2), then read back
    ld(0, 8'h05, 4'b1010, "");
    desel(); desel();
    ld(1, 8'h05, '1, "R2");
    desel(); desel(); desel();
    // R3: read right after write, alternating directions
    ld(0, 8'h09, 4'b0110, "");
    ld(1, 8'h09, '1, "");
    ld(0, 8'h0A, '0, "");
    ld(1, 8'h0B, '1, "R3");
    ld(1, 8'h0A, '1, "R3");
    desel(); desel(); desel();
    // R8: linear and interleaved bursts from base low bits 01
    ld(1, 8'h21, '1, "R8");
    for (int i = 0; i < 4; i++) adv(1, "R8");
    ld(1, 8'h21, '1, "R8");
    for (int i = 0; i < 4; i++) adv(0, "R8");
    cyc(0, 0, 0, 1, 0, 0, 0, '0, 8'h45, 0, "", "");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 1, 1, 0, 4'(i), '0, 0, "", "");
    ld(1, 8'h45, '1, "R8");
    for (int i = 0; i < 3; i++) adv(0, "R8");
    desel(); desel(); desel();
    // R4: stall mid-flight with noisy inputs
    ld(1, 8'h30, '1, "");
    ld(0, 8'h31, '0, "");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 1, 0, 0, 1, '0, 8'h31, 0, "R4", "");
    ld(1, 8'h31, '1, "");
    for (int i = 0; i < 2; i++) cyc(1, 1, 1, 0, 1, 1, 0, '0, '0, 0, "R4", "");
    desel(); desel(); desel();
    // R5, R9: deselect with reads in flight, then advances
    ld(1, 8'h40, '1, "");
    ld(1, 8'h41, '1, "");
    cyc(0, 0, 0, 0, 1, 0, 1, '1, 8'h42, 0, "", "R5");
    adv(1, "R9"); adv(1, "R9"); adv(0, "R9"); adv(1, "R9");
    // R7: output enable high during a read data phase
    ld(1, 8'h50, '1, "");
    ld(1, 8'h51, '1, "");
    desel();
    cyc(0, 1, 1, 1, 1, 0, 1, '1, '0, 1, "R7", "");
    cyc(0, 1, 1, 1, 1, 0, 1, '1, '0, 0, "", "");
    oe_n = 1'b1; #0.5;
    chk(dq_oe === 1'b0, "R7", DW'(dq_oe), '0);
    oe_n = 1'b0; #0.5;
    desel(); desel();
    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit en_n, s0, s1, s2;
      en_n = ($urandom % 10) == 0;
      s0 = ($urandom % 12) == 0;
      s1 = ($urandom % 12) == 0;
      s2 = ($urandom % 12) != 0;
      cyc(en_n, s0, s1, s2, 1'($urandom), ($urandom % 5) < 2, 1'($urandom),
          4'($urandom), 8'($urandom), ($urandom % 10) == 0, en_n ? "R4" : "", "");
    end
    for (int i = 0; i < 3; i++) desel();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule